// File: doc/BRIEF.md
# PCI Interrupt Summary and Mask Registers

This block gathers nineteen level-sensitive PCI interrupt request lines from a board and presents them to an 8-bit I/O slave interface. Three consecutive byte addresses starting at a base address (0x804 by default) each front one byte of request state. A write to one of these addresses loads the matching byte of a per-line mask, where a one disables the line. A read returns the raw request levels, not the masked ones. The mask has no read-back path.

The unmasked requests are ORed together and registered once to form a single level-sensitive interrupt output to the processor. After reset every line is disabled, so nothing reaches the processor until software clears mask bits. The bus is a simple synchronous strobe interface: an address, write data, read data, and separate write and read enables.

Top module: `irq_summary_unit`

## Requirements
- R1: After reset every mask bit is 1 (all lines disabled) and `irqOut` is 0; with all requests active and no mask write, `irqOut` stays 0.
- R2: A write (`wrEn`=1) to address base+k, k in 0..2, loads mask byte k from `wrData`, with bit j controlling line 8k+j; a 1 disables that line and a 0 enables it; the other mask bytes are unchanged.
- R3: A read (`rdEn`=1) at base+k returns the raw request levels of lines 8k..8k+7 on `rdData`, whatever the mask holds; the read data is combinational in the same cycle.
- R4: Line n appears at read byte n/8, bit n%8. The board assignment is: lines 0-3 INTA of slots 0-3, line 4 the ISA bridge, line 5 IDE, line 6 USB, line 7 INTB of slot 0, lines 8-10 INTB of slots 1-3, lines 11-14 INTC of slots 0-3, line 15 INTD of slot 0, lines 16-18 INTD of slots 1-3.
- R5: Bits 3 to 7 of byte base+2 are reserved: they read 0, and writes to them have no effect.
- R6: `irqOut` is the OR of all request lines whose mask bit is 0, registered once: it follows a change of requests or mask one clock edge later and stays 1 for as long as any enabled request stays active.
- R7: A read at any other address returns 0, and `rdData` is 0 whenever `rdEn` is 0; a write at any other address changes no mask bit.
- R8: Address and data presented with `wrEn`=0 change no mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 12 | I/O address |
| wrData | input | 8 | Write data (mask byte) |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data (raw request byte) |
| irqReq | input | 19 | Level-sensitive request lines, mapping per R4 |
| irqOut | output | 1 | Combined enabled interrupt to the processor |

## Verification
The main function is driven from a table of mask and request pairs: everything masked with everything requesting, nothing masked with nothing requesting, a single enabled line requesting alone, every line but the enabled one requesting, and single lines at the edges of each byte (0, 15, 18). These separate a mask that is ignored, a mask with inverted sense, and a byte-lane or bit-position slip. Each vector also reads all three bytes so that read data taken from the mask, or from masked requests, shows up. Directed tests cover the reset state, writes at neighbouring addresses or without the strobe, reserved read bits, and an output that must hold while a request stays and drop one edge after it goes.

// File: rtl/irq_summary_pkg.sv
package irq_summary_pkg;
  localparam int LANES  = 3;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [LANES-1:0] wrSel;
    logic [LANES-1:0] rdSel;
  } strobe_t;
endpackage

// File: rtl/irq_summary_ctrl.sv
module irq_summary_ctrl
  import irq_summary_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h804
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           strb
);
  logic [LANES-1:0] laneHit;

  for (genvar k = 0; k < LANES; k++) begin : g_decode
    assign laneHit[k] = (addr == BASE_ADDR + ADDR_W'(k));
  end

  assign strb.wrSel = wrEn ? laneHit : '0;
  assign strb.rdSel = rdEn ? laneHit : '0;

  // R2/R7: at most one lane selected per access
  assert_one_write_lane_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrSel));
  assert_one_read_lane_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.rdSel));
endmodule

// File: rtl/irq_summary_datapath.sv
module irq_summary_datapath
  import irq_summary_pkg::*;
#(
  parameter int NUM_LINES = 19
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [BYTE_W-1:0]    wrData,
  input  logic [NUM_LINES-1:0] irqReq,
  output logic [BYTE_W-1:0]    rdData,
  output logic                 irqOut
);
  localparam int PAD_W = LANES * BYTE_W;
  localparam logic [PAD_W-1:0] VALID_BITS = PAD_W'((64'd1 << NUM_LINES) - 64'd1);

  logic [NUM_LINES-1:0] maskQ;
  logic [PAD_W-1:0]     reqPad;
  logic                 anyEnabled;

  // One mask flop per existing line; reserved positions have no storage.
  for (genvar b = 0; b < NUM_LINES; b++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rstN)                     maskQ[b] <= 1'b1;
      else if (strb.wrSel[b/BYTE_W]) maskQ[b] <= wrData[b%BYTE_W];
    end
  end

  assign reqPad     = PAD_W'(irqReq);
  assign anyEnabled = |(irqReq & ~maskQ);

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= anyEnabled;
  end

  always_comb begin
    rdData = '0;
    for (int k = 0; k < LANES; k++) begin
      if (strb.rdSel[k]) rdData = reqPad[k*BYTE_W +: BYTE_W];
    end
  end

  // R1: a fully masked state never lets the output rise
  assert_masked_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |=> !irqOut);
  // R2: a write to lane 0 loads that mask byte
  assert_lane0_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSel[0] |=> maskQ[BYTE_W-1:0] == $past(wrData));
  // R8: no write strobe, no mask change
  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrSel == '0) |=> $stable(maskQ));
  // R6: output falls one edge after the last enabled request goes away
  assert_output_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq & ~maskQ) == '0 |=> !irqOut);
  // R5: reserved read positions are zero
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdSel[LANES-1] |-> (rdData & ~VALID_BITS[PAD_W-1 -: BYTE_W]) == '0);
endmodule

// File: rtl/irq_summary_unit.sv
module irq_summary_unit
  import irq_summary_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h804,
  parameter int NUM_LINES = 19
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wrData,
  input  logic                 wrEn,
  input  logic                 rdEn,
  output logic [7:0]           rdData,
  input  logic [NUM_LINES-1:0] irqReq,
  output logic                 irqOut
);
  strobe_t strb;

  irq_summary_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) i_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .strb(strb)
  );

  irq_summary_datapath #(.NUM_LINES(NUM_LINES)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .irqReq(irqReq), .rdData(rdData), .irqOut(irqOut)
  );

  // R7: idle read port drives zero
  assert_idle_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == 8'h00);
endmodule

// File: tb/test_irq_summary_unit.sv
module test_irq_summary_unit;
  localparam logic [11:0] BASE = 12'h804;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [18:0] irqReq = '0;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_summary_unit i_irq_summary_unit (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .rdEn(rdEn), .rdData(rdData), .irqReq(irqReq), .irqOut(irqOut)
  );

  // {mask (24 bits, three bytes), requests (19 bits)}
  localparam int NV = 7;
  localparam logic [42:0] VEC [NV] = '{
    {24'hFFFFFF, 19'h7FFFF},
    {24'h000000, 19'h00000},
    {24'hFFFFFE, 19'h00001},
    {24'hFFFFFE, 19'h7FFFE},
    {24'hFBFFFF, 19'h40000},
    {24'hFF7FFF, 19'h08000},
    {24'h00FFFF, 19'h0FFFF}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    addr = a; wrData = d; wrEn = en;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0]  rd;
    logic [23:0] m;
    logic [18:0] q;
    logic [23:0] qPad;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, all requests active but nothing enabled
    irqReq = '1;
    settle();
    check("R1 irqOut after reset", {7'd0, irqOut}, 8'h00);
    check("R7 rdData with rdEn low", rdData, 8'h00);

    // Table walk: R2, R3, R4, R6
    for (int v = 0; v < NV; v++) begin
      m = VEC[v][42:19];
      q = VEC[v][18:0];
      qPad = {5'd0, q};
      for (int k = 0; k < 3; k++) busWrite(BASE + 12'(k), m[k*8 +: 8], 1'b1);
      irqReq = q;
      settle();
      check("R2/R6 irqOut vs mask and requests", {7'd0, irqOut},
            {7'd0, |(q & ~m[18:0])});
      for (int k = 0; k < 3; k++) begin
        busRead(BASE + 12'(k), rd);
        check("R3/R4 raw request byte", rd, qPad[k*8 +: 8]);
      end
    end

    // R5: reserved read bits are zero with all requests active
    irqReq = '1;
    busRead(BASE + 12'd2, rd);
    check("R5 reserved bits read zero", rd, 8'h07);

    // Restore full mask, then stray writes must not enable anything (R7, R8)
    for (int k = 0; k < 3; k++) busWrite(BASE + 12'(k), 8'hFF, 1'b1);
    busWrite(BASE + 12'd3, 8'h00, 1'b1);
    busWrite(BASE - 12'd1, 8'h00, 1'b1);
    settle();
    check("R7 write at other address ignored", {7'd0, irqOut}, 8'h00);
    busWrite(BASE, 8'h00, 1'b0);
    busWrite(BASE + 12'd1, 8'h00, 1'b0);
    settle();
    check("R8 write without strobe ignored", {7'd0, irqOut}, 8'h00);
    busRead(BASE + 12'd3, rd);
    check("R7 read at other address", rd, 8'h00);
    busRead(12'h000, rd);
    check("R7 read at address zero", rd, 8'h00);

    // R5: reserved write bits have no effect; enable only line 17 via byte 2
    busWrite(BASE + 12'd2, 8'hFD, 1'b1);
    irqReq = 19'h20000;
    settle();
    check("R5 byte2 write enables line 17", {7'd0, irqOut}, 8'h01);

    // R6: level hold then drop one edge later
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check("R6 output held while request active", {7'd0, irqOut}, 8'h01);
    end
    irqReq = 19'h00000;
    @(negedge clk);
    check("R6 output drops one edge after request", {7'd0, irqOut}, 8'h00);

    // R1: reset again restores full mask
    rstN = 1'b0;
    settle();
    rstN = 1'b1;
    irqReq = '1;
    settle();
    check("R1 mask all ones after second reset", {7'd0, irqOut}, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule